// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing for a raster display, either a CRT-style monitor or a flat panel. It counts pixel clocks along each line and lines within each frame. From these counts it drives a display-enable strobe, two horizontal pulses (a CRT sync and a panel line pulse) and two vertical pulses (a CRT sync and a panel frame pulse). Each of these four pulses has its own polarity. The current pixel and line indices are also output so that a downstream address generator can follow the raster.

Host software programs the timing through byte-wide register writes. Horizontal quantities are counted in groups of eight pixels, and vertical quantities are counted in lines. Each field stores its count minus one. Writes go into a pending bank, which software can read back at once. The pending bank is copied into the working bank only when the raster wraps from the last pixel of the frame to pixel 0 of line 0, so every frame uses a single consistent set of values. A read-only flag, visible both on a port and in the register map, shows when the raster is in the vertical non-display band.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is held and after it is released, `pix_x` and `line_y` are 0, every register reads back 0, and all four sync outputs sit at their inactive level. With polarity bits of 0 the inactive level is 1.
- R2: A line lasts 8*(A+1) + 8*(B+1) pixel clocks, where A is the active-width field and B is the horizontal non-display field. `pix_x` counts up by one each clock from 0 to the line length minus 1, then returns to 0.
- R3: A frame lasts (H+1) + (N+1) lines, where H is the 10-bit active-height field and N is the vertical non-display field. `line_y` advances only when `pix_x` wraps, and it returns to 0 after the last line.
- R4: `de` is 1 exactly when `pix_x` < 8*(A+1) and `line_y` < H+1.
- R5: The horizontal pulse is active for pixels p where p >= 8*(A+1) + 8*S and p < that start + 8*(W+1). S is the horizontal sync offset field and W is the horizontal sync width field.
- R6: The vertical pulse is active for whole lines l where l >= (H+1) + T and l < that start + (U+1). T is the vertical sync offset field and U is the vertical sync width field.
- R7: A pulse never extends past the end of its non-display period. If a pulse would start at or beyond the line or frame end, it does not appear at all.
- R8: Bit 7 of the horizontal width register sets the polarity of `crt_hsync`, and bit 6 sets the polarity of `lcd_line`. Bits 7 and 6 of the vertical width register do the same for `crt_vsync` and `lcd_frame`. A value of 1 means active-high and 0 means active-low. Each output follows only its own bit.
- R9: A write takes effect in the timing only from the first pixel of the next frame. A read of the written address returns the new value on the following clock.
- R10: `vnd_status` is 1 exactly when `line_y` >= H+1. Bit 7 of address 6 reads this flag, and writes to that bit have no effect.
- R11: Register map, with fields low-aligned and unused bits reading 0:
  - address 0: A, 7 bits
  - address 1: B, 5 bits
  - address 2: S, 5 bits
  - address 3: W in bits [3:0], with polarity bits 7 and 6
  - address 4: H bits [7:0]
  - address 5: H bits [9:8] in bits [1:0]
  - address 6: N in bits [5:0], with the status flag in bit 7
  - address 7: T, 6 bits
  - address 8: U in bits [2:0], with polarity bits 7 and 6

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write byte |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read byte (pending values plus status) |
| de | output | 1 | Display enable |
| crt_hsync | output | 1 | CRT horizontal sync |
| lcd_line | output | 1 | Panel line pulse |
| crt_vsync | output | 1 | CRT vertical sync |
| lcd_frame | output | 1 | Panel frame pulse |
| vnd_status | output | 1 | Vertical non-display flag |
| pix_x | output | HCNT_W (12) | Current pixel index within the line |
| line_y | output | VCNT_W (12) | Current line index within the frame |

## Verification
The hardest situation to reach from the ports is a register write that lands in the middle of a frame. The design must keep running the old timing until the wrap and then switch to the new timing cleanly.

The stimulus writes a new active width a few pixels into line 0 of the reset configuration. It first checks that the readback already shows the new value. It then checks that the current frame still wraps its lines at the old length, and that the next frame runs past that old length.

Pulse clipping and the case of a pulse starting beyond the end of its period are also hard to provoke. They are reached with table entries whose offset plus width deliberately overrun the non-display period, and whose frame needs the upper height bits.

// File: rtl/tg_pkg.sv
package tg_pkg;

  typedef enum logic [3:0] {
    REG_HACT    = 4'd0,
    REG_HND     = 4'd1,
    REG_HSS     = 4'd2,
    REG_HSW     = 4'd3,
    REG_VACT_LO = 4'd4,
    REG_VACT_HI = 4'd5,
    REG_VND     = 4'd6,
    REG_VSS     = 4'd7,
    REG_VSW     = 4'd8
  } tg_reg_e;

  localparam int POL_CRT_BIT    = 7;
  localparam int POL_PANEL_BIT  = 6;
  localparam int VND_STATUS_BIT = 7;

  // Map a raw pulse to the pin level: pol_high=1 drives the pulse as a 1.
  function automatic logic drive_level(input logic pulse, input logic pol_high);
    return pol_high ? pulse : ~pulse;
  endfunction

endpackage

// File: rtl/tg_regfile.sv
module tg_regfile
  import tg_pkg::*;
#(
  parameter int HACT_W = 7,
  parameter int HND_W  = 5,
  parameter int HSS_W  = 5,
  parameter int HSW_W  = 4,
  parameter int VACT_W = 10,
  parameter int VND_W  = 6,
  parameter int VSS_W  = 6,
  parameter int VSW_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [3:0]        rd_addr,
  output logic [7:0]        rd_data,
  input  logic              vnd_flag,
  input  logic              apply,
  output logic [HACT_W-1:0] a_hact,
  output logic [HND_W-1:0]  a_hnd,
  output logic [HSS_W-1:0]  a_hss,
  output logic [HSW_W-1:0]  a_hsw,
  output logic              a_hs_pol_crt,
  output logic              a_hs_pol_pan,
  output logic [VACT_W-1:0] a_vact,
  output logic [VND_W-1:0]  a_vnd,
  output logic [VSS_W-1:0]  a_vss,
  output logic [VSW_W-1:0]  a_vsw,
  output logic              a_vs_pol_crt,
  output logic              a_vs_pol_pan
);

  localparam int VHI_W = VACT_W - 8;

  // Pending bank: host-visible, written immediately.
  logic [HACT_W-1:0] p_hact;
  logic [HND_W-1:0]  p_hnd;
  logic [HSS_W-1:0]  p_hss;
  logic [HSW_W-1:0]  p_hsw;
  logic              p_hs_pc, p_hs_pp;
  logic [VACT_W-1:0] p_vact;
  logic [VND_W-1:0]  p_vnd;
  logic [VSS_W-1:0]  p_vss;
  logic [VSW_W-1:0]  p_vsw;
  logic              p_vs_pc, p_vs_pp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_hact  <= '0;
      p_hnd   <= '0;
      p_hss   <= '0;
      p_hsw   <= '0;
      p_hs_pc <= 1'b0;
      p_hs_pp <= 1'b0;
      p_vact  <= '0;
      p_vnd   <= '0;
      p_vss   <= '0;
      p_vsw   <= '0;
      p_vs_pc <= 1'b0;
      p_vs_pp <= 1'b0;
    end else if (wr_en) begin
      case (tg_reg_e'(wr_addr))
        REG_HACT:    p_hact <= wr_data[HACT_W-1:0];
        REG_HND:     p_hnd  <= wr_data[HND_W-1:0];
        REG_HSS:     p_hss  <= wr_data[HSS_W-1:0];
        REG_HSW: begin
          p_hsw   <= wr_data[HSW_W-1:0];
          p_hs_pc <= wr_data[POL_CRT_BIT];
          p_hs_pp <= wr_data[POL_PANEL_BIT];
        end
        REG_VACT_LO: p_vact[7:0] <= wr_data;
        REG_VACT_HI: p_vact[VACT_W-1:8] <= wr_data[VHI_W-1:0];
        REG_VND:     p_vnd  <= wr_data[VND_W-1:0];
        REG_VSS:     p_vss  <= wr_data[VSS_W-1:0];
        REG_VSW: begin
          p_vsw   <= wr_data[VSW_W-1:0];
          p_vs_pc <= wr_data[POL_CRT_BIT];
          p_vs_pp <= wr_data[POL_PANEL_BIT];
        end
        default: ;
      endcase
    end
  end

  // Readback returns pending values; status bit is live.
  always_comb begin
    rd_data = '0;
    case (tg_reg_e'(rd_addr))
      REG_HACT:    rd_data[HACT_W-1:0] = p_hact;
      REG_HND:     rd_data[HND_W-1:0]  = p_hnd;
      REG_HSS:     rd_data[HSS_W-1:0]  = p_hss;
      REG_HSW: begin
        rd_data[HSW_W-1:0]     = p_hsw;
        rd_data[POL_CRT_BIT]   = p_hs_pc;
        rd_data[POL_PANEL_BIT] = p_hs_pp;
      end
      REG_VACT_LO: rd_data = p_vact[7:0];
      REG_VACT_HI: rd_data[VHI_W-1:0] = p_vact[VACT_W-1:8];
      REG_VND: begin
        rd_data[VND_W-1:0]      = p_vnd;
        rd_data[VND_STATUS_BIT] = vnd_flag;
      end
      REG_VSS:     rd_data[VSS_W-1:0] = p_vss;
      REG_VSW: begin
        rd_data[VSW_W-1:0]     = p_vsw;
        rd_data[POL_CRT_BIT]   = p_vs_pc;
        rd_data[POL_PANEL_BIT] = p_vs_pp;
      end
      default: rd_data = '0;
    endcase
  end

  // Working bank: copied only at the frame wrap.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_hact       <= '0;
      a_hnd        <= '0;
      a_hss        <= '0;
      a_hsw        <= '0;
      a_hs_pol_crt <= 1'b0;
      a_hs_pol_pan <= 1'b0;
      a_vact       <= '0;
      a_vnd        <= '0;
      a_vss        <= '0;
      a_vsw        <= '0;
      a_vs_pol_crt <= 1'b0;
      a_vs_pol_pan <= 1'b0;
    end else if (apply) begin
      a_hact       <= p_hact;
      a_hnd        <= p_hnd;
      a_hss        <= p_hss;
      a_hsw        <= p_hsw;
      a_hs_pol_crt <= p_hs_pc;
      a_hs_pol_pan <= p_hs_pp;
      a_vact       <= p_vact;
      a_vnd        <= p_vnd;
      a_vss        <= p_vss;
      a_vsw        <= p_vsw;
      a_vs_pol_crt <= p_vs_pc;
      a_vs_pol_pan <= p_vs_pp;
    end
  end

endmodule

// File: rtl/tg_axis_counter.sv
module tg_axis_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] total,
  output logic [W-1:0] pos,
  output logic         wrap
);

  assign wrap = step && (pos == total - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos <= '0;
    else if (wrap)   pos <= '0;
    else if (step)   pos <= pos + W'(1);
  end

endmodule

// File: rtl/tg_sync_shaper.sv
module tg_sync_shaper
  import tg_pkg::*;
#(
  parameter int W = 12
) (
  input  logic [W-1:0] pos,
  input  logic [W-1:0] start,
  input  logic [W-1:0] width,
  input  logic [W-1:0] total,
  input  logic         pol_crt,
  input  logic         pol_pan,
  output logic         in_pulse,
  output logic         out_crt,
  output logic         out_pan
);

  // Window [start, start+width) clipped at the period end.
  function automatic logic in_window(input logic [W-1:0] p, input logic [W-1:0] s,
                                     input logic [W-1:0] w, input logic [W-1:0] t);
    logic [W:0] stop;
    stop = {1'b0, s} + {1'b0, w};
    return (p >= s) && ({1'b0, p} < stop) && (p < t);
  endfunction

  assign in_pulse = in_window(pos, start, width, total);
  assign out_crt  = drive_level(in_pulse, pol_crt);
  assign out_pan  = drive_level(in_pulse, pol_pan);

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import tg_pkg::*;
#(
  parameter int HACT_W    = 7,
  parameter int HND_W     = 5,
  parameter int HSS_W     = 5,
  parameter int HSW_W     = 4,
  parameter int VACT_W    = 10,
  parameter int VND_W     = 6,
  parameter int VSS_W     = 6,
  parameter int VSW_W     = 3,
  parameter int UNIT_LOG2 = 3,
  parameter int HCNT_W    = $clog2(((2**HACT_W) + (2**HND_W) + (2**HSS_W) + (2**HSW_W)) << UNIT_LOG2) + 1,
  parameter int VCNT_W    = $clog2((2**VACT_W) + (2**VND_W) + (2**VSS_W) + (2**VSW_W)) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [3:0]        rd_addr,
  output logic [7:0]        rd_data,
  output logic              de,
  output logic              crt_hsync,
  output logic              lcd_line,
  output logic              crt_vsync,
  output logic              lcd_frame,
  output logic              vnd_status,
  output logic [HCNT_W-1:0] pix_x,
  output logic [VCNT_W-1:0] line_y
);

  // Count-minus-one field scaled to a pixel length.
  function automatic logic [HCNT_W-1:0] px_len(input logic [HCNT_W-1:0] f);
    return (f + HCNT_W'(1)) << UNIT_LOG2;
  endfunction

  // Count-minus-one field to a line count.
  function automatic logic [VCNT_W-1:0] ln_len(input logic [VCNT_W-1:0] f);
    return f + VCNT_W'(1);
  endfunction

  logic [HACT_W-1:0] a_hact;
  logic [HND_W-1:0]  a_hnd;
  logic [HSS_W-1:0]  a_hss;
  logic [HSW_W-1:0]  a_hsw;
  logic              a_hs_pol_crt, a_hs_pol_pan;
  logic [VACT_W-1:0] a_vact;
  logic [VND_W-1:0]  a_vnd;
  logic [VSS_W-1:0]  a_vss;
  logic [VSW_W-1:0]  a_vsw;
  logic              a_vs_pol_crt, a_vs_pol_pan;

  logic              h_wrap, v_wrap, frame_apply;
  logic              hs_pulse, vs_pulse, vnd_flag;
  logic [HCNT_W-1:0] h_act, h_tot, hs_start, hs_width;
  logic [VCNT_W-1:0] v_act, v_tot, vs_start, vs_width;

  tg_regfile #(
    .HACT_W(HACT_W), .HND_W(HND_W), .HSS_W(HSS_W), .HSW_W(HSW_W),
    .VACT_W(VACT_W), .VND_W(VND_W), .VSS_W(VSS_W), .VSW_W(VSW_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .vnd_flag(vnd_flag), .apply(frame_apply),
    .a_hact(a_hact), .a_hnd(a_hnd), .a_hss(a_hss), .a_hsw(a_hsw),
    .a_hs_pol_crt(a_hs_pol_crt), .a_hs_pol_pan(a_hs_pol_pan),
    .a_vact(a_vact), .a_vnd(a_vnd), .a_vss(a_vss), .a_vsw(a_vsw),
    .a_vs_pol_crt(a_vs_pol_crt), .a_vs_pol_pan(a_vs_pol_pan)
  );

  // Derived limits from the working bank.
  assign h_act    = px_len(HCNT_W'(a_hact));
  assign h_tot    = h_act + px_len(HCNT_W'(a_hnd));
  assign hs_start = h_act + (HCNT_W'(a_hss) << UNIT_LOG2);
  assign hs_width = px_len(HCNT_W'(a_hsw));

  assign v_act    = ln_len(VCNT_W'(a_vact));
  assign v_tot    = v_act + ln_len(VCNT_W'(a_vnd));
  assign vs_start = v_act + VCNT_W'(a_vss);
  assign vs_width = ln_len(VCNT_W'(a_vsw));

  tg_axis_counter #(.W(HCNT_W)) hcnt_i (
    .clk(clk), .rst_n(rst_n), .step(1'b1), .total(h_tot),
    .pos(pix_x), .wrap(h_wrap)
  );

  tg_axis_counter #(.W(VCNT_W)) vcnt_i (
    .clk(clk), .rst_n(rst_n), .step(h_wrap), .total(v_tot),
    .pos(line_y), .wrap(v_wrap)
  );

  assign frame_apply = h_wrap && v_wrap;

  tg_sync_shaper #(.W(HCNT_W)) hsync_i (
    .pos(pix_x), .start(hs_start), .width(hs_width), .total(h_tot),
    .pol_crt(a_hs_pol_crt), .pol_pan(a_hs_pol_pan),
    .in_pulse(hs_pulse), .out_crt(crt_hsync), .out_pan(lcd_line)
  );

  tg_sync_shaper #(.W(VCNT_W)) vsync_i (
    .pos(line_y), .start(vs_start), .width(vs_width), .total(v_tot),
    .pol_crt(a_vs_pol_crt), .pol_pan(a_vs_pol_pan),
    .in_pulse(vs_pulse), .out_crt(crt_vsync), .out_pan(lcd_frame)
  );

  assign vnd_flag   = (line_y >= v_act);
  assign vnd_status = vnd_flag;
  assign de         = (pix_x < h_act) && !vnd_flag;

endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
  parameter int HCNT_W = 12,
  parameter int VCNT_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [HCNT_W-1:0] pix_x,
  input logic [VCNT_W-1:0] line_y,
  input logic              h_wrap,
  input logic              frame_apply,
  input logic [HCNT_W-1:0] h_tot,
  input logic [VCNT_W-1:0] v_tot,
  input logic              de,
  input logic              vnd_flag,
  input logic              hs_pulse,
  input logic              vs_pulse
);

  assert_pix_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x != '0) |-> (pix_x == HCNT_W'($past(pix_x) + HCNT_W'(1))));

  assert_pix_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    h_wrap |=> (pix_x == '0));

  assert_line_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !h_wrap |=> $stable(line_y));

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_apply |=> ($stable(h_tot) && $stable(v_tot)));

  assert_de_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (!vnd_flag && !hs_pulse && !vs_pulse));

  assert_vsync_in_band_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vs_pulse |-> vnd_flag);

  assert_hsync_in_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hs_pulse |-> (pix_x < h_tot));

endmodule

bind raster_timing_gen tg_checker #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .line_y(line_y),
  .h_wrap(h_wrap), .frame_apply(frame_apply), .h_tot(h_tot), .v_tot(v_tot),
  .de(de), .vnd_flag(vnd_flag), .hs_pulse(hs_pulse), .vs_pulse(vs_pulse)
);

// File: tb/raster_timing_gen_tb_top.sv
module raster_timing_gen_tb_top;

  localparam int HCNT_W = 12;
  localparam int VCNT_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [3:0]        wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic [3:0]        rd_addr = '0;
  logic [7:0]        rd_data;
  logic              de, crt_hsync, lcd_line, crt_vsync, lcd_frame, vnd_status;
  logic [HCNT_W-1:0] pix_x;
  logic [VCNT_W-1:0] line_y;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  raster_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .de(de), .crt_hsync(crt_hsync),
    .lcd_line(lcd_line), .crt_vsync(crt_vsync), .lcd_frame(lcd_frame),
    .vnd_status(vnd_status), .pix_x(pix_x), .line_y(line_y)
  );

  // One row per configuration, bytes in register address order 0..8 (R11).
  localparam logic [7:0] VEC [0:3][0:8] = '{
    '{8'h01, 8'h01, 8'h00, 8'h80, 8'h03, 8'h00, 8'h02, 8'h00, 8'h40},
    '{8'h00, 8'h01, 8'h01, 8'hC3, 8'h02, 8'h00, 8'h01, 8'h00, 8'h87},
    '{8'h02, 8'h02, 8'h02, 8'h00, 8'h01, 8'h00, 8'h03, 8'h03, 8'hC1},
    '{8'h03, 8'h00, 8'h01, 8'h40, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_pos(input int x, input int y);
    do @(negedge clk); while (!(int'(pix_x) == x && int'(line_y) == y));
  endtask

  task automatic run_vector(input int v);
    int ha, ht, hs0, hs1, va, vt, vs0, vs1;
    bit hp, vp, hpc, hpp, vpc, vpp, exp_de;
    for (int r = 0; r < 9; r++) wr(4'(r), VEC[v][r]);
    ha  = 8 * (int'(VEC[v][0][6:0]) + 1);
    ht  = ha + 8 * (int'(VEC[v][1][4:0]) + 1);
    hs0 = ha + 8 * int'(VEC[v][2][4:0]);
    hs1 = hs0 + 8 * (int'(VEC[v][3][3:0]) + 1);
    if (hs1 > ht) hs1 = ht;
    va  = (int'(VEC[v][5][1:0]) * 256) + int'(VEC[v][4]) + 1;
    vt  = va + int'(VEC[v][6][5:0]) + 1;
    vs0 = va + int'(VEC[v][7][5:0]);
    vs1 = vs0 + int'(VEC[v][8][2:0]) + 1;
    if (vs1 > vt) vs1 = vt;
    hpc = VEC[v][3][7]; hpp = VEC[v][3][6];
    vpc = VEC[v][8][7]; vpp = VEC[v][8][6];
    // New values appear only from the next frame start (R9).
    wait_pos(0, 0);
    for (int y = 0; y < vt; y++) begin
      for (int x = 0; x < ht; x++) begin
        hp = (x >= hs0) && (x < hs1);
        vp = (y >= vs0) && (y < vs1);
        exp_de = (x < ha) && (y < va);
        check(int'(pix_x) == x, "R2 pixel index", int'(pix_x), x);
        check(int'(line_y) == y, "R3 line index", int'(line_y), y);
        check(de == exp_de, "R4 display enable", de, exp_de);
        check(crt_hsync == (hpc ? hp : !hp), "R5 R7 R8 crt_hsync", crt_hsync, hpc ? hp : !hp);
        check(lcd_line == (hpp ? hp : !hp), "R5 R7 R8 lcd_line", lcd_line, hpp ? hp : !hp);
        check(crt_vsync == (vpc ? vp : !vp), "R6 R7 R8 crt_vsync", crt_vsync, vpc ? vp : !vp);
        check(lcd_frame == (vpp ? vp : !vp), "R6 R7 R8 lcd_frame", lcd_frame, vpp ? vp : !vp);
        check(vnd_status == (y >= va), "R10 status port", vnd_status, y >= va);
        @(negedge clk);
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog R1 R2 R3 actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(pix_x == '0 && line_y == '0, "R1 counters in reset", int'(pix_x), 0);
    check(crt_hsync && lcd_line && crt_vsync && lcd_frame, "R1 syncs inactive in reset",
          int'({crt_hsync, lcd_line, crt_vsync, lcd_frame}), 15);
    rst_n = 1'b1;
    check(pix_x == '0 && line_y == '0, "R1 counters after release", int'(pix_x), 0);
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), d);
      check(d == 8'h00, "R1 R11 register reset value", d, 0);
    end
    check(crt_hsync && lcd_line && crt_vsync && lcd_frame, "R1 syncs inactive after release",
          int'({crt_hsync, lcd_line, crt_vsync, lcd_frame}), 15);

    // R10: status bit write ignored, flag readable. Reset frame: 16 px x 2 lines.
    @(negedge clk);
    wr(4'd6, 8'h80);
    rd(4'd6, d);
    check(d == 8'h00, "R10 status bit not writable (active line)", d, 8'h00);
    check(vnd_status == 1'b0, "R10 status port low in active line", vnd_status, 0);
    wait_pos(0, 1);
    rd(4'd6, d);
    check(d == 8'h80, "R10 status bit in non-display line", d, 8'h80);
    check(vnd_status == 1'b1, "R10 status port high in non-display", vnd_status, 1);

    // R9: mid-frame write applies at the next frame only.
    wait_pos(3, 0);
    wr(4'd0, 8'h05);
    rd(4'd0, d);
    check(d == 8'h05, "R9 R11 pending readback", d, 8'h05);
    wait_pos(15, 0);
    @(negedge clk);
    check(pix_x == '0 && line_y == 12'd1, "R9 old line length kept", int'(pix_x), 0);
    wait_pos(15, 1);
    @(negedge clk);
    check(pix_x == '0 && line_y == '0, "R9 frame wrap on old timing", int'(line_y), 0);
    repeat (16) @(negedge clk);
    check(pix_x == 12'd16 && line_y == '0, "R9 new line length in next frame", int'(pix_x), 16);

    // Table of configurations, each scanned over one full frame.
    for (int v = 0; v < 4; v++) run_vector(v);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule